// File: doc/BRIEF.md
# Refill Interrupt and Trap Arbiter

At each instruction boundary the arbiter decides how control should continue. It looks at four things: a deferred page-crossing flag, an interrupt hint, the real wakeup state, and three hardware error sources. From these it picks exactly one outcome. It can resume normally, correct the program counter onto the next page, save state while the PC still sits on a page's last word, take an interrupt, or trap.

The interrupt hint is never trusted on its own. A real interrupt is taken only when the wakeup-disable counter is zero and the pending-wakeups word is nonzero. While the crossing flag is set, interrupts are not examined at all. Error sources are ranked by code, and any error wins over every other outcome.

The arbiter owns the crossing flag and the hint bit. Refill logic sets the flag (which also raises the hint), I/O logic raises the hint, and jump/transfer logic clears the flag. A one-cycle `eval_i` strobe asks for a decision, and the result appears on the registered outputs one clock later.

Top module: `refill_trap_arbiter`

## Requirements
- R1: During and right after reset, `act_o`, `cross_o`, `hint_o` and `refill_two_o` are all zero.
- R2: `cross_set_i` sets both the crossing flag and the hint, and `hint_set_i` sets the hint. `cross_clr_i` clears the flag. When both set and clear arrive in the same cycle, set wins, and both set requests also override an evaluation's result.
- R3: When any error input is high at an evaluation, the action is trap (`act_o` bit 4). `err_code_o` then gives the lowest-numbered active source: 1 boot, 2 stack, 3 buffer-empty.
- R4: After a trap, the crossing flag is clear and the hint is set.
- R5: A buffer-empty trap reports the next page: `vpage_o` = `vpage_i` + `PAGE_WORDS`. Any other trap reports `vpage_i` unchanged.
- R6: With no error and the hint clear, the action is continue (bit 0), and the flag and hint keep their values.
- R7: With the hint and flag set and `last_word_i` low, the action is fix-PC (bit 1). `vpage_o` = `vpage_i` + `PAGE_WORDS`, the flag clears, and `refill_two_o` equals `buf_empty_i`.
- R8: With the hint and flag set and `last_word_i` high, the action is save-state (bit 2). The flag and hint stay set, and the wakeup state is ignored.
- R9: With the hint set and the flag clear, a zero disable counter together with a nonzero wakeups word gives interrupt (bit 3).
- R10: With the hint set and the flag clear, but no qualifying wakeup, the action is continue and the hint clears.
- R11: `act_o` is one-hot for exactly the one cycle after each `eval_i` strobe, and zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eval_i | input | 1 | Decision strobe at an instruction boundary |
| cross_set_i | input | 1 | Set crossing flag and hint |
| cross_clr_i | input | 1 | Clear crossing flag |
| hint_set_i | input | 1 | Raise interrupt hint |
| last_word_i | input | 1 | PC is on the last word of its page |
| buf_empty_i | input | 1 | Instruction buffer is empty |
| wdc_i | input | WDC_W | Wakeup-disable counter |
| wake_i | input | WAKE_W | Pending-wakeups word |
| err_i | input | N_ERR | Error sources, bit k is code k+1 |
| vpage_i | input | VA_W | Current virtual PC page base |
| act_o | output | 5 | One-hot action {trap, intr, save, fix, continue} |
| err_code_o | output | 2 | Ranked error code of a trap |
| vpage_o | output | VA_W | Page to retranslate or fault on |
| refill_two_o | output | 1 | Fix-PC refill must fetch two words |
| cross_o | output | 1 | Crossing flag state |
| hint_o | output | 1 | Interrupt hint state |

## Verification
The assertions assume `eval_i` is a single-cycle pulse and that every decision input is stable at the edge where it is sampled. The trap check also assumes that no `cross_set_i` arrives in the same cycle as the strobe. The bench drives all inputs on the falling edge and raises each strobe for exactly one cycle. Set and clear requests are kept away from evaluation cycles, except in the one directed test of set precedence.

// File: rtl/rta_pkg.sv
package rta_pkg;
  localparam int ACT_W    = 5;
  localparam int ACT_CONT = 0;
  localparam int ACT_FIX  = 1;
  localparam int ACT_SAVE = 2;
  localparam int ACT_INTR = 3;
  localparam int ACT_TRAP = 4;
  localparam int CODE_W   = 2;
  localparam logic [CODE_W-1:0] CODE_IBEMPTY = 2'd3;
  typedef logic [ACT_W-1:0] act_t;
endpackage

// File: rtl/rta_err_rank.sv
module rta_err_rank #(
  parameter int N_ERR  = 3,
  parameter int CODE_W = 2
) (
  input  logic [N_ERR-1:0]  err_i,
  output logic [CODE_W-1:0] code_o
);
  // lowest index wins: scan from the top so the last hit is the smallest
  always_comb begin
    code_o = '0;
    for (int k = N_ERR - 1; k >= 0; k--) begin
      if (err_i[k]) code_o = CODE_W'(k + 1);
    end
  end
endmodule

// File: rtl/rta_wake_qual.sv
module rta_wake_qual #(
  parameter int WDC_W  = 8,
  parameter int WAKE_W = 16
) (
  input  logic [WDC_W-1:0]  wdc_i,
  input  logic [WAKE_W-1:0] wake_i,
  output logic              irq_ok_o
);
  always_comb irq_ok_o = (wdc_i == '0) && (|wake_i);
endmodule

// File: rtl/rta_decide.sv
module rta_decide
  import rta_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  input  logic              cross_i,
  input  logic              hint_i,
  input  logic              last_word_i,
  input  logic              irq_ok_i,
  output act_t              act_o,
  output logic              inc_page_o,
  output logic              nx_cross_o,
  output logic              nx_hint_o
);
  always_comb begin
    act_o      = '0;
    inc_page_o = 1'b0;
    nx_cross_o = cross_i;
    nx_hint_o  = hint_i;
    if (code_i != '0) begin
      act_o[ACT_TRAP] = 1'b1;
      nx_cross_o      = 1'b0;
      nx_hint_o       = 1'b1;          // error clear drops the hint; re-raise it
      inc_page_o      = (code_i == CODE_IBEMPTY);
    end else if (!hint_i) begin
      act_o[ACT_CONT] = 1'b1;
    end else if (cross_i) begin
      if (!last_word_i) begin
        act_o[ACT_FIX] = 1'b1;
        inc_page_o     = 1'b1;
        nx_cross_o     = 1'b0;
      end else begin
        act_o[ACT_SAVE] = 1'b1;
      end
    end else if (irq_ok_i) begin
      act_o[ACT_INTR] = 1'b1;
    end else begin
      act_o[ACT_CONT] = 1'b1;
      nx_hint_o       = 1'b0;
    end
  end
endmodule

// File: rtl/refill_trap_arbiter.sv
module refill_trap_arbiter
  import rta_pkg::*;
#(
  parameter int WDC_W      = 8,
  parameter int WAKE_W     = 16,
  parameter int N_ERR      = 3,
  parameter int VA_W       = 24,
  parameter int PAGE_WORDS = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic              cross_set_i,
  input  logic              cross_clr_i,
  input  logic              hint_set_i,
  input  logic              last_word_i,
  input  logic              buf_empty_i,
  input  logic [WDC_W-1:0]  wdc_i,
  input  logic [WAKE_W-1:0] wake_i,
  input  logic [N_ERR-1:0]  err_i,
  input  logic [VA_W-1:0]   vpage_i,
  output logic [ACT_W-1:0]  act_o,
  output logic [CODE_W-1:0] err_code_o,
  output logic [VA_W-1:0]   vpage_o,
  output logic              refill_two_o,
  output logic              cross_o,
  output logic              hint_o
);
  localparam logic [VA_W-1:0] PAGE_STEP = VA_W'(PAGE_WORDS);

  logic [CODE_W-1:0] code_w;
  logic              irq_ok_w, inc_w, dcross_w, dhint_w;
  act_t              dact_w;

  rta_err_rank #(.N_ERR(N_ERR), .CODE_W(CODE_W)) u_rank (
    .err_i(err_i), .code_o(code_w));

  rta_wake_qual #(.WDC_W(WDC_W), .WAKE_W(WAKE_W)) u_qual (
    .wdc_i(wdc_i), .wake_i(wake_i), .irq_ok_o(irq_ok_w));

  rta_decide u_dec (
    .code_i(code_w), .cross_i(cross_o), .hint_i(hint_o),
    .last_word_i(last_word_i), .irq_ok_i(irq_ok_w),
    .act_o(dact_w), .inc_page_o(inc_w),
    .nx_cross_o(dcross_w), .nx_hint_o(dhint_w));

  logic              cross_n, hint_n, two_n;
  logic [ACT_W-1:0]  act_n;
  logic [CODE_W-1:0] code_n;
  logic [VA_W-1:0]   vpage_n;
  logic              rec_en;

  always_comb begin
    rec_en  = eval_i;
    cross_n = cross_o;
    hint_n  = hint_o;
    act_n   = '0;
    two_n   = 1'b0;
    code_n  = err_code_o;
    vpage_n = vpage_o;
    if (eval_i) begin
      cross_n = dcross_w;
      hint_n  = dhint_w;
      act_n   = dact_w;
      code_n  = code_w;
      vpage_n = inc_w ? (vpage_i + PAGE_STEP) : vpage_i;
      two_n   = dact_w[ACT_FIX] & buf_empty_i;
    end
    if (cross_clr_i) cross_n = 1'b0;
    if (hint_set_i)  hint_n  = 1'b1;
    if (cross_set_i) begin
      cross_n = 1'b1;
      hint_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cross_o      <= 1'b0;
      hint_o       <= 1'b0;
      act_o        <= '0;
      refill_two_o <= 1'b0;
    end else begin
      cross_o      <= cross_n;
      hint_o       <= hint_n;
      act_o        <= act_n;
      refill_two_o <= two_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_code_o <= '0;
      vpage_o    <= '0;
    end else if (rec_en) begin
      err_code_o <= code_n;
      vpage_o    <= vpage_n;
    end
  end

  AST_ACT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_o)) else $error("act not onehot0"); // R11
  AST_ACT_AFTER_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i |=> $countones(act_o) == 1) else $error("no action after eval"); // R11
  AST_TRAP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && (|err_i) && !cross_set_i && !cross_clr_i |=> act_o[ACT_TRAP] && !cross_o && hint_o)
    else $error("trap state wrong"); // R4
  AST_SAVE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && !cross_clr_i && cross_o && hint_o && last_word_i && !(|err_i) |=> act_o[ACT_SAVE] && cross_o)
    else $error("save lost flag"); // R8
  AST_FIX_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && cross_o && hint_o && !last_word_i && !(|err_i) |=> act_o[ACT_FIX] && vpage_o == $past(vpage_i) + PAGE_STEP)
    else $error("fix page wrong"); // R7
  AST_INTR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    eval_i && !cross_o && hint_o && !(|err_i) && (wdc_i != '0 || wake_i == '0) |=> !act_o[ACT_INTR])
    else $error("unqualified interrupt"); // R9
endmodule

// File: tb/refill_trap_arbiter_tb.sv
module refill_trap_arbiter_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic eval_i, cross_set_i, cross_clr_i, hint_set_i, last_word_i, buf_empty_i;
  logic [7:0]  wdc_i;
  logic [15:0] wake_i;
  logic [2:0]  err_i;
  logic [23:0] vpage_i;
  logic [4:0]  act_o;
  logic [1:0]  err_code_o;
  logic [23:0] vpage_o;
  logic        refill_two_o, cross_o, hint_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [4:0] A_CONT = 5'b00001, A_FIX = 5'b00010, A_SAVE = 5'b00100,
                         A_INTR = 5'b01000, A_TRAP = 5'b10000;

  always #10 clk = ~clk;  // 50 MHz

  refill_trap_arbiter u_dut (
    .clk(clk), .rst_n(rst_n), .eval_i(eval_i), .cross_set_i(cross_set_i),
    .cross_clr_i(cross_clr_i), .hint_set_i(hint_set_i), .last_word_i(last_word_i),
    .buf_empty_i(buf_empty_i), .wdc_i(wdc_i), .wake_i(wake_i), .err_i(err_i),
    .vpage_i(vpage_i), .act_o(act_o), .err_code_o(err_code_o), .vpage_o(vpage_o),
    .refill_two_o(refill_two_o), .cross_o(cross_o), .hint_o(hint_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    eval_i = 0; cross_set_i = 0; cross_clr_i = 0; hint_set_i = 0;
    last_word_i = 0; buf_empty_i = 0; wdc_i = 0; wake_i = 0; err_i = 0;
    vpage_i = 24'h001200;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic pulse_cross();
    cross_set_i = 1; step(); cross_set_i = 0;
  endtask

  task automatic pulse_hint();
    hint_set_i = 1; step(); hint_set_i = 0;
  endtask

  task automatic do_eval();
    eval_i = 1; step(); eval_i = 0;
  endtask

  task automatic reset_dut();
    idle_inputs();
    rst_n = 0;
    repeat (2) step();
    rst_n = 1;
    step();
  endtask

  task automatic t_reset();
    reset_dut();
    chk("R1 act", act_o, 0);
    chk("R1 cross", cross_o, 0);
    chk("R1 hint", hint_o, 0);
    chk("R1 two", refill_two_o, 0);
  endtask

  task automatic t_flags();
    reset_dut();
    pulse_hint();
    chk("R2 hint set", hint_o, 1);
    chk("R2 hint no flag", cross_o, 0);
    reset_dut();
    pulse_cross();
    chk("R2 cross set flag", cross_o, 1);
    chk("R2 cross set hint", hint_o, 1);
    cross_clr_i = 1; step(); cross_clr_i = 0;
    chk("R2 clear", cross_o, 0);
    cross_clr_i = 1; cross_set_i = 1; step(); cross_clr_i = 0; cross_set_i = 0;
    chk("R2 set wins", cross_o, 1);
  endtask

  task automatic t_idle();
    reset_dut();
    wake_i = 16'h0004;
    do_eval();
    chk("R6 act", act_o, A_CONT);
    chk("R6 hint", hint_o, 0);
    chk("R6 cross", cross_o, 0);
    step();
    chk("R11 act drops", act_o, 0);
  endtask

  task automatic t_fix(input logic empty);
    reset_dut();
    pulse_cross();
    buf_empty_i = empty; vpage_i = 24'h003400;
    do_eval();
    chk("R7 act", act_o, A_FIX);
    chk("R7 page", vpage_o, 24'h003500);
    chk("R7 flag clear", cross_o, 0);
    chk("R7 two words", refill_two_o, empty);
    chk("R7 hint kept", hint_o, 1);
  endtask

  task automatic t_save();
    reset_dut();
    pulse_cross();
    last_word_i = 1; wdc_i = 0; wake_i = 16'h8000;
    do_eval();
    chk("R8 act", act_o, A_SAVE);
    chk("R8 flag kept", cross_o, 1);
    chk("R8 hint kept", hint_o, 1);
  endtask

  task automatic t_intr();
    reset_dut();
    pulse_hint();
    wdc_i = 0; wake_i = 16'h0100;
    do_eval();
    chk("R9 act", act_o, A_INTR);
    step();
    chk("R11 single cycle", act_o, 0);
  endtask

  task automatic t_ignore(input logic [7:0] w, input logic [15:0] k);
    reset_dut();
    pulse_hint();
    wdc_i = w; wake_i = k;
    do_eval();
    chk("R10 act", act_o, A_CONT);
    chk("R10 hint cleared", hint_o, 0);
  endtask

  task automatic t_trap(input logic [2:0] e, input logic [1:0] code, input logic nxt);
    reset_dut();
    pulse_cross();
    err_i = e; vpage_i = 24'h00AB00;
    do_eval();
    err_i = 0;
    chk("R3 act", act_o, A_TRAP);
    chk("R3 code", err_code_o, code);
    chk("R4 flag clear", cross_o, 0);
    chk("R4 hint set", hint_o, 1);
    chk("R5 page", vpage_o, nxt ? 24'h00AC00 : 24'h00AB00);
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_flags();
    t_idle();
    t_fix(1'b1);
    t_fix(1'b0);
    t_save();
    t_intr();
    t_ignore(8'd2, 16'h0010);
    t_ignore(8'd0, 16'h0000);
    t_trap(3'b111, 2'd1, 1'b0);
    t_trap(3'b110, 2'd2, 1'b0);
    t_trap(3'b100, 2'd3, 1'b1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule